// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer programmed over a small synchronous register port. Software sets up a timer entry that holds an 8-bit interrupt vector, a mask bit and a mode bit. It picks a prescale ratio for the input clock and then writes a start value into the initial-count register. From that write on, the live counter steps down by one on each prescaled tick. The value it holds can be read at any time through the current-count register.

When the counter steps from one to zero and the entry is unmasked, the block raises a one-cycle interrupt request together with the programmed vector. In periodic mode the counter reloads and runs again. In one-shot mode it rests at zero, and software arms the next event by writing a fresh initial count. With the mask set, the counter keeps running but no request is raised. This lets software measure the tick rate against another time base with interrupts off, and it is also how the timer is shut down.

Top module: `lcl_irq_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (mask set, vector 0, one-shot mode), the initial count, the current count and the divide code read 0, and the interrupt request is low.
- R2: The timer entry sits at word address 0. The vector is bits 7:0, the mask is bit 16 and the mode is bit 17 (1 = periodic, 0 = one-shot). All other bits are ignored on write and read back as 0.
- R3: A write to the initial-count register (address 1) loads that value into the counter and restarts the prescaler. With a ratio of D, the first decrement lands on the D-th clock edge after the write edge. A rewrite while counting starts the countdown over.
- R4: The current-count register (address 2) returns the live counter value. Read data is registered: it appears one cycle after the address is presented and reflects the value held before that edge. Writes to this address change nothing.
- R5: The divide register (address 3) keeps only bits 0, 1 and 3, taken as the code {bit3, bit1, bit0}. Codes 0 through 6 select divide-by-2, 4, 8, 16, 32, 64 and 128, and code 7 selects divide-by-1. All other bits read back as 0.
- R6: Each prescaled tick lowers a non-zero count by exactly one.
- R7: The step from one to zero with the mask clear raises the interrupt request for exactly one cycle, in the cycle after that edge, and the interrupt vector output carries the entry's vector.
- R8: With the mask set, the counter runs in the same way but no interrupt request is raised.
- R9: In one-shot mode the counter stays at zero after expiry until the initial count is written again.
- R10: In periodic mode, on the first tick after reaching zero the counter reloads from the initial count. The interrupt period is therefore (N+1)·D cycles.
- R11: Writing an initial count of zero stops the counter at zero and raises no interrupt.
- R12: Reads of addresses 4 to 15 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable, one write per cycle |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
Every result is due a fixed number of edges after its cause. Read data follows the presented address by one edge. After a write to the initial count, the first decrement follows by D edges. The request follows by N·D edges, and in periodic mode it repeats every (N+1)·D edges. The bench model works from the same edge inputs as the design, updates its expectations at the rising edge and compares at the following falling edge. The directed tests count falling edges from the write and require the request to arrive at exactly 5, 48, 6 and 14 edges, and at 10 edges after a restart, with no extra pulses.

// File: rtl/lit_pkg.sv
// Package: shared constants and types for the local interrupt countdown timer.
// Assumes a 4-bit word address and a data word of at least 18 bits.
package lit_pkg;
    localparam int ADDR_W   = 4;
    localparam int VEC_W    = 8;
    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;
    localparam int CODE_W   = 3;
    // Largest finite ratio is 2^(6+1) = 128, so 7 prescaler bits suffice.
    localparam int PRE_W    = 7;

    localparam logic [ADDR_W-1:0] A_ENTRY = 4'd0;
    localparam logic [ADDR_W-1:0] A_INIT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CUR   = 4'd2;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd3;

    localparam logic [CODE_W-1:0] CODE_DIV1 = 3'b111;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_t;
endpackage

// File: rtl/lit_regs.sv
// Module: register file and registered read port of the timer.
// Holds the timer entry, the initial count and the divide code, and emits a
// load strobe when the initial count is written. Assumes DATA_W >= 18 and
// COUNT_W <= DATA_W.
module lit_regs #(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [lit_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      we,
    input  logic [COUNT_W-1:0]        cur_count,
    output lit_pkg::entry_t           entry,
    output logic [COUNT_W-1:0]        init_count,
    output logic [lit_pkg::CODE_W-1:0] div_code,
    output logic                      load,
    output logic [DATA_W-1:0]         rdata
);
    import lit_pkg::*;

    entry_t              entry_q;
    logic [COUNT_W-1:0]  init_q;
    logic [CODE_W-1:0]   code_q;
    logic [DATA_W-1:0]   rd_d;
    logic [DATA_W-1:0]   rd_q;

    // Decode the initial-count write that (re)starts the countdown.
    always_comb load = we && (addr == A_INIT);

    // Capture writes to the entry, initial count and divide registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
            init_q  <= '0;
            code_q  <= '0;
        end else if (we) begin
            case (addr)
                A_ENTRY: begin
                    entry_q.vector   <= wdata[VEC_W-1:0];
                    entry_q.mask     <= wdata[MASK_BIT];
                    entry_q.periodic <= wdata[MODE_BIT];
                end
                A_INIT:  init_q <= wdata[COUNT_W-1:0];
                A_DIV:   code_q <= {wdata[3], wdata[1], wdata[0]};
                default: ;
            endcase
        end
    end

    // Select the read value for the presented address.
    always_comb begin
        rd_d = '0;
        case (addr)
            A_ENTRY: begin
                rd_d[VEC_W-1:0] = entry_q.vector;
                rd_d[MASK_BIT]  = entry_q.mask;
                rd_d[MODE_BIT]  = entry_q.periodic;
            end
            A_INIT: rd_d[COUNT_W-1:0] = init_q;
            A_CUR:  rd_d[COUNT_W-1:0] = cur_count;
            A_DIV: begin
                rd_d[0] = code_q[0];
                rd_d[1] = code_q[1];
                rd_d[3] = code_q[2];
            end
            default: rd_d = '0;
        endcase
    end

    // Register the read data so that it is due one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign entry      = entry_q;
    assign init_count = init_q;
    assign div_code   = code_q;
    assign rdata      = rd_q;

    // A write to the current-count address leaves all state alone.
    assert_cur_readonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CUR) |=> ($stable(entry_q) && $stable(init_q) && $stable(code_q)));

    // A write to an unmapped address leaves all state alone.
    assert_unmapped_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > A_DIV) |=> ($stable(entry_q) && $stable(init_q) && $stable(code_q)));
endmodule

// File: rtl/lit_prescaler.sv
// Module: clock prescaler producing a tick every 1, 2, 4 ... 128 cycles.
// A free-running counter is cleared by the load strobe, so the first tick
// after a load falls exactly D cycles later. Assumes the divide code is 3 bits.
module lit_prescaler (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [lit_pkg::CODE_W-1:0] div_code,
    output logic                       tick
);
    import lit_pkg::*;

    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] sel_mask;

    // Build the low-bit mask whose all-ones pattern marks a tick.
    always_comb begin
        sel_mask = '0;
        if (div_code != CODE_DIV1) begin
            for (int i = 0; i < PRE_W; i++) begin
                if (i <= int'(div_code)) sel_mask[i] = 1'b1;
            end
        end
    end

    // Advance the prescale counter and restart it on a load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pcnt_q <= '0;
        else                 pcnt_q <= pcnt_q + 1'b1;
    end

    // Raise a tick when the selected low bits are all ones.
    always_comb tick = ((pcnt_q & sel_mask) == sel_mask);

    // Any ratio above one cannot tick on two cycles in a row.
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_code != CODE_DIV1) |=> (!tick || div_code == CODE_DIV1));
endmodule

// File: rtl/lit_counter.sv
// Module: the countdown register and the interrupt pulse.
// Loads on the load strobe, decrements on each tick, reloads in periodic
// mode and raises a mask-qualified one-cycle request on the step to zero.
module lit_counter #(
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [COUNT_W-1:0]        load_val,
    input  logic [COUNT_W-1:0]        init_count,
    input  logic                      tick,
    input  lit_pkg::entry_t           entry,
    output logic [COUNT_W-1:0]        count,
    output logic                      irq,
    output logic [lit_pkg::VEC_W-1:0] irq_vec
);
    import lit_pkg::*;

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    logic [COUNT_W-1:0] count_q;
    logic               irq_q;
    logic [VEC_W-1:0]   vec_q;

    // Count down, reload or hold, and fire on the one-to-zero step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            if (load) begin
                count_q <= load_val;
            end else if (tick) begin
                if (count_q > ONE) begin
                    count_q <= count_q - ONE;
                end else if (count_q == ONE) begin
                    count_q <= '0;
                    irq_q   <= !entry.mask;
                    vec_q   <= entry.vector;
                end else if (entry.periodic) begin
                    count_q <= init_count;
                end
            end
        end
    end

    assign count   = count_q;
    assign irq     = irq_q;
    assign irq_vec = vec_q;

    // The request lasts exactly one cycle.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // No request follows a cycle with the mask set.
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !$past(entry.mask));

    // A one-shot counter at zero stays there until reloaded.
    assert_oneshot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && !entry.periodic && !load) |=> (count_q == '0));

    // The live count never exceeds the programmed initial count.
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= init_count);

    // Loading zero leaves the counter stopped and quiet.
    assert_zero_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (count_q == '0 && !irq_q));
endmodule

// File: rtl/lcl_irq_timer.sv
// Module: top of the local interrupt countdown timer.
// Connects the register file, the prescaler and the countdown. Assumes one
// register access per cycle and DATA_W >= 18, COUNT_W <= DATA_W.
module lcl_irq_timer #(
    parameter int DATA_W  = 32,
    parameter int COUNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [lit_pkg::ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      we,
    output logic [DATA_W-1:0]         rdata,
    output logic                      irq_req,
    output logic [lit_pkg::VEC_W-1:0] irq_vector
);
    import lit_pkg::*;

    entry_t              entry;
    logic [COUNT_W-1:0]  init_count;
    logic [COUNT_W-1:0]  cur_count;
    logic [CODE_W-1:0]   div_code;
    logic                load;
    logic                tick;

    lit_regs #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (wdata),
        .we         (we),
        .cur_count  (cur_count),
        .entry      (entry),
        .init_count (init_count),
        .div_code   (div_code),
        .load       (load),
        .rdata      (rdata)
    );

    lit_prescaler i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load),
        .div_code (div_code),
        .tick     (tick)
    );

    lit_counter #(.COUNT_W(COUNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (wdata[COUNT_W-1:0]),
        .init_count (init_count),
        .tick       (tick),
        .entry      (entry),
        .count      (cur_count),
        .irq        (irq_req),
        .irq_vec    (irq_vector)
    );
endmodule

// File: tb/test_lcl_irq_timer.sv
module test_lcl_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    lcl_irq_timer i_lcl_irq_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_count = 0, m_init = 0, m_rdata = 0;
    logic [7:0]  m_vec = 0, m_vecout = 0;
    logic        m_mask = 1, m_per = 0, m_irq = 0;
    int          m_code = 0;
    int          m_since = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: next state from the inputs seen at this edge.
    always @(posedge clk) begin
        int d;
        logic tk;
        logic [31:0] rd;
        if (!rst_n) begin
            m_count = 0; m_init = 0; m_rdata = 0; m_vec = 0; m_vecout = 0;
            m_mask = 1; m_per = 0; m_irq = 0; m_code = 0; m_since = 0;
        end else begin
            d  = (m_code == 7) ? 1 : (2 << m_code);
            tk = ((m_since % d) == d - 1);
            case (addr)
                4'd0: rd = {14'd0, m_per, m_mask, 8'd0, m_vec};
                4'd1: rd = m_init;
                4'd2: rd = m_count;
                4'd3: rd = {28'd0, m_code[2], 1'b0, m_code[1], m_code[0]};
                default: rd = 0;
            endcase
            m_rdata = rd;
            m_irq = 0;
            if (we && addr == 4'd1) begin
                m_count = wdata; m_since = 0;
            end else begin
                m_since++;
                if (tk) begin
                    if (m_count > 1) m_count = m_count - 1;
                    else if (m_count == 1) begin
                        m_count = 0; m_irq = !m_mask; m_vecout = m_vec;
                    end else if (m_per) m_count = m_init;
                end
            end
            if (we) begin
                if (addr == 4'd0) begin
                    m_vec = wdata[7:0]; m_mask = wdata[16]; m_per = wdata[17];
                end else if (addr == 4'd1) m_init = wdata;
                else if (addr == 4'd3) m_code = {29'd0, wdata[3], wdata[1], wdata[0]};
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        chk(cur_req, rdata, m_rdata);
        chk(cur_req, {31'd0, irq_req}, {31'd0, m_irq});
        if (m_irq) chk(cur_req, {24'd0, irq_vector}, {24'd0, m_vecout});
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        addr = a; wdata = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic first_irq(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (irq_req && k == 0) k = i;
        end
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_req) c++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int k, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        rd(4'd0, v); chk("R1", v, 32'h0001_0000);
        rd(4'd1, v); chk("R1", v, 32'h0);
        rd(4'd2, v); chk("R1", v, 32'h0);
        rd(4'd3, v); chk("R1", v, 32'h0);
        chk("R1", {31'd0, irq_req}, 32'h0);
        // R2 entry field positions
        cur_req = "R2";
        wr(4'd0, 32'hFFFC_FF5A);
        rd(4'd0, v); chk("R2", v, 32'h0000_005A);
        // R5 divide encoding
        cur_req = "R5";
        wr(4'd3, 32'hFFFF_FFF4);
        rd(4'd3, v); chk("R5", v, 32'h0);
        wr(4'd3, 32'h0000_000B);
        rd(4'd3, v); chk("R5", v, 32'h0000_000B);
        // R7 R9 one-shot, divide-by-1, count 5
        cur_req = "R7";
        wr(4'd1, 32'd5);
        first_irq(5, k); chk("R7", k, 5);
        chk("R7", {24'd0, irq_vector}, 32'h5A);
        count_irq(20, c); chk("R9", c, 0);
        rd(4'd2, v); chk("R9", v, 32'h0);
        // R3 R6 divide-by-16, count 3
        cur_req = "R6";
        wr(4'd3, 32'h3);
        wr(4'd1, 32'd3);
        first_irq(48, k); chk("R3", k, 48);
        // R3 restart by rewrite, divide-by-1
        cur_req = "R3";
        wr(4'd3, 32'hB);
        wr(4'd1, 32'd10);
        repeat (3) @(negedge clk);
        wr(4'd1, 32'd10);
        first_irq(12, k); chk("R3", k, 10);
        // R8 masked periodic keeps counting
        cur_req = "R8";
        wr(4'd0, 32'h0003_005A);
        wr(4'd1, 32'd4);
        rd(4'd2, v); rd(4'd2, v2);
        chk("R8", {31'd0, v != v2}, 32'h1);
        count_irq(30, c); chk("R8", c, 0);
        // R10 periodic divide-by-2, count 3: period 8
        cur_req = "R10";
        wr(4'd0, 32'h0002_0033);
        wr(4'd3, 32'h0);
        wr(4'd1, 32'd3);
        first_irq(6, k); chk("R10", k, 6);
        first_irq(8, k); chk("R10", k, 8);
        chk("R10", {24'd0, irq_vector}, 32'h33);
        // R4 current count is read-only
        cur_req = "R4";
        wr(4'd2, 32'h1234);
        rd(4'd1, v); chk("R4", v, 32'd3);
        rd(4'd2, v); chk("R4", {31'd0, v <= 32'd3}, 32'h1);
        // R11 zero initial count stops the counter
        cur_req = "R11";
        wr(4'd1, 32'd0);
        count_irq(40, c); chk("R11", c, 0);
        rd(4'd2, v); chk("R11", v, 32'h0);
        // R12 unmapped addresses
        cur_req = "R12";
        wr(4'd7, 32'hFFFF_FFFF);
        rd(4'd7, v); chk("R12", v, 32'h0);
        rd(4'd0, v); chk("R12", v, 32'h0002_0033);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule